// File: doc/BRIEF.md
# Resolution-Scaled Watchdog Timer

This block is a memory-mapped watchdog. Software programs a reload count, a tick resolution and two enable bits through a 32-bit control word. It reads the running counter back through a second, read-only word. The watchdog tick comes from a fixed-rate base pulse of 2^15 per second. A 15-bit prescaler divides that pulse by 2^(15 - resolution), so one tick lasts 1/2^resolution seconds. The range runs from one second at resolution 0 down to about 30.5 µs at resolution 15.

Every write to the control word is also a keepalive. The new fields take effect at once, and a busy flag is raised for a fixed number of clocks. When the busy period ends, the counter is reloaded from the written count. While the watchdog is enabled, the counter falls by one on each tick. Once it sits at zero with reset-enable set, a registered reset request goes high and stays high until the next control write or a hard reset.

Top module: `scaled_watchdog`

## Requirements
- R1: A hard reset sets the control word to reload count 0xFFFFF and resolution 0, with enable, reset-enable and busy clear. It also sets the current count to 0 and drops the reset request.
- R2: A control-word read gives reload count in bits 19:0, resolution in bits 23:20, reset-enable in bit 26, enable in bit 27 and busy in bit 28. All other bits read as 0. The control word is at byte offset 0x0 and the current count is at 0x4, in bits 19:0. Any other offset reads 0.
- R3: A control write sets busy. Busy reads 1 for exactly LOAD_CYCLES clocks after the write edge and then clears by itself. During that period the current count keeps its old value.
- R4: When busy clears, the current count equals the reload count that was written.
- R5: While enable is set and busy is clear, each tick lowers a nonzero count by exactly one. With resolution 15, every base pulse is a tick.
- R6: After a control write clears the prescaler, the reset request rises after exactly count × 2^(15 − resolution) base pulses. This holds for every resolution.
- R7: With enable clear, base pulses do not change the current count and no reset request is raised.
- R8: With reset-enable clear, the count stops at zero and no reset request is raised.
- R9: The reset request stays high across further base pulses. A control write lowers it on the write edge.
- R10: A write to offset 0x4 changes neither the current count nor the control word, and it does not start a busy period.
- R11: A control write during a busy period restarts the busy period, and the later count is the one loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high hard reset |
| base_tick | input | 1 | One-clock pulse at 2^15 per second |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| rst_req | output | 1 | Latched system reset request |

## Verification
The hardest case to reach from the ports is expiry at the slowest resolution, which needs 32768 base pulses per tick. The bench drives the base pulse directly from the test at one pulse every two clocks. It counts pulses from the write that cleared the prescaler until the request rises, across resolutions 8 to 15 and also at 4 and 0. Back-to-back control writes exercise the restart of the busy window. They are checked at the clock where the first load would otherwise have landed.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    parameter int CNT_W   = 20;
    parameter int RES_W   = 4;
    parameter int PRESC_W = (1 << RES_W) - 1;
    parameter int WORD_W  = 32;
    parameter int ADDR_W  = 4;

    localparam logic [ADDR_W-1:0] OFF_CTRL  = 4'h0;
    localparam logic [ADDR_W-1:0] OFF_COUNT = 4'h4;

    localparam int POS_RES  = 20;
    localparam int POS_SRST = 26;
    localparam int POS_EN   = 27;
    localparam int POS_BUSY = 28;

    typedef struct packed {
        logic             srst_en;
        logic             en;
        logic [RES_W-1:0] res;
        logic [CNT_W-1:0] count;
    } wdt_cfg_t;

    localparam wdt_cfg_t CFG_RESET = '{srst_en: 1'b0, en: 1'b0, res: '0, count: '1};

    function automatic wdt_cfg_t word_to_cfg(input logic [WORD_W-1:0] w);
        wdt_cfg_t c;
        c.count   = w[CNT_W-1:0];
        c.res     = w[POS_RES +: RES_W];
        c.srst_en = w[POS_SRST];
        c.en      = w[POS_EN];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] cfg_to_word(input wdt_cfg_t c, input logic busy);
        logic [WORD_W-1:0] w;
        w = '0;
        w[CNT_W-1:0]         = c.count;
        w[POS_RES +: RES_W]  = c.res;
        w[POS_SRST]          = c.srst_en;
        w[POS_EN]            = c.en;
        w[POS_BUSY]          = busy;
        return w;
    endfunction

    function automatic logic [PRESC_W-1:0] div_mask(input logic [RES_W-1:0] r);
        return {PRESC_W{1'b1}} >> r;
    endfunction
endpackage

// File: rtl/wdt_ctrl_regs.sv
module wdt_ctrl_regs
    import wdt_pkg::*;
#(
    parameter int LOAD_CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  cur_count,
    output logic [WORD_W-1:0] bus_rdata,
    output wdt_cfg_t          cfg,
    output logic              busy,
    output logic              load_now,
    output logic              wr_ctrl
);
    localparam int BCW = (LOAD_CYCLES > 1) ? $clog2(LOAD_CYCLES) : 1;

    logic [BCW-1:0] busy_left;
    wire unused_wbits = ^{bus_wdata[WORD_W-1:POS_BUSY], bus_wdata[POS_SRST-1:POS_RES+RES_W]};

    assign wr_ctrl  = bus_valid && bus_write && (bus_addr == OFF_CTRL);
    assign load_now = busy && (busy_left == '0) && !wr_ctrl;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= CFG_RESET;
            busy      <= 1'b0;
            busy_left <= '0;
        end else if (wr_ctrl) begin
            cfg       <= word_to_cfg(bus_wdata);
            busy      <= 1'b1;
            busy_left <= BCW'(LOAD_CYCLES - 1);
        end else if (load_now) begin
            busy      <= 1'b0;
        end else if (busy) begin
            busy_left <= busy_left - 1'b1;
        end
    end

    always_comb begin
        case (bus_addr)
            OFF_CTRL:  bus_rdata = cfg_to_word(cfg, busy);
            OFF_COUNT: bus_rdata = WORD_W'(cur_count);
            default:   bus_rdata = '0;
        endcase
    end

    // R3: the last busy clock is followed by a clear busy unless rewritten
    assert_busy_ends_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && busy_left == '0 && !wr_ctrl) |=> !busy);
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             run,
    input  logic             base_tick,
    input  logic [RES_W-1:0] res,
    output logic             tick
);
    logic [PRESC_W-1:0] presc;
    logic [PRESC_W-1:0] mask;

    assign mask = div_mask(res);
    assign tick = run && base_tick && ((presc & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || clr)
            presc <= '0;
        else if (run && base_tick)
            presc <= presc + 1'b1;
    end
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             en,
    input  logic             srst_en,
    input  logic             busy,
    input  logic             tick,
    input  logic             clr_req,
    output logic [CNT_W-1:0] cur,
    output logic             rst_req
);
    logic expired;
    assign expired = en && srst_en && !busy && (cur == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur     <= '0;
            rst_req <= 1'b0;
        end else begin
            if (load)
                cur <= load_val;
            else if (tick && en && !busy && cur != '0)
                cur <= cur - 1'b1;

            if (clr_req)
                rst_req <= 1'b0;
            else if (expired)
                rst_req <= 1'b1;
        end
    end

    // R5: one tick removes exactly one count
    assert_single_step_R5: assert property (@(posedge clk) disable iff (rst)
        (tick && en && !busy && !load && cur != '0) |=> (cur == $past(cur) - 1'b1));
    // R8: a request only rises with reset-enable on and the count at zero
    assert_req_needs_srst_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_req) |-> (srst_en && cur == '0));
endmodule

// File: rtl/scaled_watchdog.sv
module scaled_watchdog
    import wdt_pkg::*;
#(
    parameter int LOAD_CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              base_tick,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              rst_req
);
    wdt_cfg_t         cfg;
    logic             busy;
    logic             load_now;
    logic             wr_ctrl;
    logic             tick;
    logic [CNT_W-1:0] cur;

    wdt_ctrl_regs #(.LOAD_CYCLES(LOAD_CYCLES)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cur_count (cur),
        .bus_rdata (bus_rdata),
        .cfg       (cfg),
        .busy      (busy),
        .load_now  (load_now),
        .wr_ctrl   (wr_ctrl)
    );

    wdt_prescaler u_presc (
        .clk       (clk),
        .rst       (rst),
        .clr       (wr_ctrl),
        .run       (cfg.en && !busy),
        .base_tick (base_tick),
        .res       (cfg.res),
        .tick      (tick)
    );

    wdt_countdown u_count (
        .clk      (clk),
        .rst      (rst),
        .load     (load_now),
        .load_val (cfg.count),
        .en       (cfg.en),
        .srst_en  (cfg.srst_en),
        .busy     (busy),
        .tick     (tick),
        .clr_req  (wr_ctrl),
        .cur      (cur),
        .rst_req  (rst_req)
    );

    // R4: the count equals the written reload value when busy falls
    assert_loaded_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (cur == cfg.count));
    // R7: a disabled, idle watchdog holds its count
    assert_hold_disabled_R7: assert property (@(posedge clk) disable iff (rst)
        (!cfg.en && !busy && !wr_ctrl) |=> $stable(cur));
    // R9: a control write drops the request on its edge
    assert_write_clears_req_R9: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> !rst_req);
    // R10: a write to the count word starts no busy period
    assert_count_write_inert_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && bus_addr == OFF_COUNT && !busy) |=> !busy);
endmodule

// File: tb/scaled_watchdog_test.sv
module scaled_watchdog_test;
    localparam int L = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        base_tick = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_req;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    scaled_watchdog #(.LOAD_CYCLES(L)) uut (
        .clk(clk), .rst(rst), .base_tick(base_tick), .bus_valid(bus_valid),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rst_req(rst_req)
    );

    function automatic logic [31:0] ctl(input bit en, input bit srst, input int res, input int cnt);
        return (32'(en) << 27) | (32'(srst) << 26) | (32'(res & 15) << 20) | (32'(cnt) & 32'hFFFFF);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic peek(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic pulse();
        base_tick = 1'b1;
        @(negedge clk);
        base_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic settle();
        repeat (L + 1) @(negedge clk);
    endtask

    task automatic expiry_run(input int res, input int cnt);
        int n;
        int exp_n;
        exp_n = cnt << (15 - res);
        wr(4'h0, ctl(1, 1, res, cnt));
        settle();
        n = 0;
        while (!rst_req && n <= exp_n + 2) begin
            pulse();
            n++;
        end
        check($sformatf("R6 res=%0d", res), 32'(n), 32'(exp_n));
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 / R2: reset state through both words
        peek(4'h0, d); check("R1 ctrl", d, 32'h000FFFFF);
        peek(4'h4, d); check("R1 count", d, 32'h0);
        check("R1 req", 32'(rst_req), 0);
        peek(4'h8, d); check("R2 unmapped", d, 32'h0);

        // R2: reserved bits read zero
        wr(4'h0, 32'hFFFFFFFF);
        settle();
        peek(4'h0, d); check("R2 reserved", d, 32'h0CFFFFFF);
        peek(4'h4, d); check("R2 count word", d, 32'h000FFFFF);

        // R3 / R4: busy window and load
        wr(4'h0, ctl(0, 0, 15, 37));
        for (int k = 0; k < L; k++) begin
            peek(4'h0, d); check("R3 busy set", 32'(d[28]), 1);
            peek(4'h4, d); check("R3 count held", d, 32'h000FFFFF);
            @(negedge clk);
        end
        peek(4'h0, d); check("R3 busy clear", 32'(d[28]), 0);
        peek(4'h4, d); check("R4 loaded", d, 32'd37);

        // R7: disabled watchdog ignores ticks
        for (int k = 0; k < 3; k++) pulse();
        peek(4'h4, d); check("R7 held", d, 32'd37);
        check("R7 no req", 32'(rst_req), 0);

        // R10: count word is read-only
        wr(4'h4, 32'h00000123);
        peek(4'h0, d); check("R10 no busy", d, ctl(0, 0, 15, 37));
        peek(4'h4, d); check("R10 count", d, 32'd37);

        // R5: one decrement per base pulse at resolution 15
        wr(4'h0, ctl(1, 0, 15, 5));
        settle();
        for (int k = 1; k <= 5; k++) begin
            pulse();
            peek(4'h4, d); check("R5 step", d, 32'(5 - k));
        end
        // R8: no request without reset-enable
        for (int k = 0; k < 3; k++) pulse();
        peek(4'h4, d); check("R8 stays zero", d, 32'h0);
        check("R8 no req", 32'(rst_req), 0);

        // R11: rewrite during busy restarts the window
        wr(4'h0, ctl(0, 0, 2, 100));
        wr(4'h0, ctl(0, 0, 2, 200));
        repeat (L - 1) @(negedge clk);
        peek(4'h0, d); check("R11 still busy", 32'(d[28]), 1);
        peek(4'h4, d); check("R11 no early load", d, 32'h0);
        @(negedge clk);
        peek(4'h0, d); check("R11 busy done", 32'(d[28]), 0);
        peek(4'h4, d); check("R11 later value", d, 32'd200);

        // R6: expiry timing across resolutions
        for (int r = 8; r <= 15; r++) expiry_run(r, 2);
        expiry_run(4, 1);
        expiry_run(0, 1);

        // R9: request latches, then a write clears it
        for (int k = 0; k < 4; k++) pulse();
        check("R9 latched", 32'(rst_req), 1);
        wr(4'h0, ctl(1, 1, 15, 3));
        check("R9 cleared", 32'(rst_req), 0);
        settle();
        check("R9 low after reload", 32'(rst_req), 0);

        // R1: hard reset mid-operation
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        peek(4'h0, d); check("R1 rereset ctrl", d, 32'h000FFFFF);
        peek(4'h4, d); check("R1 rereset count", d, 32'h0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (190000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule